// File: doc/BRIEF.md
# Validation Event Trigger Counters

This block holds four up-counters, one each for a system reset event, an interrupt event, a fast interrupt event and a debug request event. Software presets a counter through a load port, then starts it with an operation write. A running counter advances by one on every clock. When it rolls over from all-ones to zero, it pulls its active-low event line, and a test harness turns that line into the matching system event at a chosen cycle. To get an event N counting cycles after counting begins, software loads all-ones minus N.

An operation write carries a 2-bit primary code and a 3-bit secondary code. Code 0 starts and code 2 stops a set of the first three counters. For these two codes the secondary field is a lane mask. Code 1 starts the debug counter and code 3 stops it, and for these two codes the secondary field is ignored. A separate control write clears the sticky overflow state of the first three counters. The first three counters can be read back through a registered read port. The debug counter and the operation port always read as zero.

Top module: `valevt_trigger`

## Requirements
- R1: After a synchronous reset all counters are zero and stopped, every event output is high (inactive), and every read returns zero.
- R2: Primary code 0 starts the counters picked by the secondary mask: bit 0 selects reset, bit 1 interrupt, bit 2 fast interrupt. Counting starts late by one clock. If the write is sampled at edge a, the first increment happens at edge a+2. A stop sampled at edge a+1 leaves the value untouched.
- R3: Primary code 1 starts the debug counter and primary code 3 stops it, for any secondary value, including 0.
- R4: Primary code 2 stops the counters picked by the mask, with the same bit-to-lane mapping as R2. No increment happens at the edge that samples the stop. A stopped counter holds its value. Lanes outside the mask keep running.
- R5: A write with primary code 0 or 2 and secondary value 0 has no effect. No counter starts and no running counter stops.
- R6: A running counter at all-ones wraps to zero. Its event output goes low at that same edge. A counter loaded with all-ones minus N and started at edge a drives its event low after edge a+N+2, and not before.
- R7: Two or more counters that wrap at the same edge all drive their event outputs low at that edge.
- R8: An event output stays low until it is released. Setting control bit 10 releases the reset lane, bit 9 the fast interrupt lane and bit 8 the interrupt lane. The release takes effect after the edge that samples the control write. Stopping a counter also releases its event. The debug event is released only by a stop.
- R9: A load writes the value to the counter picked by the load select (0 reset, 1 interrupt, 2 fast interrupt, 3 debug). A load takes priority over counting, and counting carries on from the loaded value at the next edge.
- R10: Read select 0, 1 or 2 returns that counter's value one clock later. Select 3 (debug counter), select 4 (operation port) and selects 5 to 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| op_we | input | 1 | Operation write strobe |
| op_opc1 | input | 2 | Primary operation code |
| op_opc2 | input | 3 | Secondary code, a lane mask for codes 0 and 2 |
| ld_we | input | 1 | Counter load strobe |
| ld_sel | input | 2 | Counter picked for the load |
| ld_data | input | CNT_W | Load value |
| ctl_we | input | 1 | Control write strobe for overflow release |
| ctl_data | input | CTL_W | Control word; bits 10, 9 and 8 release the overflow state |
| rd_sel | input | 3 | Read select |
| rd_data | output | CNT_W | Registered read data |
| evt_rst_n | output | 1 | Reset event, active low |
| evt_irq_n | output | 1 | Interrupt event, active low |
| evt_fiq_n | output | 1 | Fast interrupt event, active low |
| evt_dbg_n | output | 1 | Debug request event, active low |

## Verification
The bench builds the block with CNT_W set to 8 and CTL_W left at 32. With an 8-bit counter, a wrap happens within a few cycles of a near-full preset, so single-lane, multi-lane and debug-lane wraps can all be exercised, and a post-wrap count can be read back, in a short run. The 32-bit control word keeps the release bits at their true positions. All expected counter values are computed from the sampling edge of each start, stop and load. This pins down the one-clock start delay, the suppressed increment on a stop, and load-over-count priority to the exact cycle.

// File: rtl/vtc_pkg.sv
package vtc_pkg;
  localparam int NUM_LANES = 4;

  typedef enum logic [1:0] {
    LANE_RST = 2'd0,
    LANE_IRQ = 2'd1,
    LANE_FIQ = 2'd2,
    LANE_DBG = 2'd3
  } lane_e;

  typedef enum logic [1:0] {
    OPC_START_MASK = 2'd0,
    OPC_START_DBG  = 2'd1,
    OPC_STOP_MASK  = 2'd2,
    OPC_STOP_DBG   = 2'd3
  } opc_e;

  localparam int REL_BIT_RST = 10;
  localparam int REL_BIT_FIQ = 9;
  localparam int REL_BIT_IRQ = 8;

  localparam logic [NUM_LANES-1:0] READABLE_LANES = 4'b0111;
endpackage

// File: rtl/vtc_op_decode.sv
module vtc_op_decode
  import vtc_pkg::*;
#(
  parameter int LANES = NUM_LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_we,
  input  logic [1:0]       opc1,
  input  logic [2:0]       opc2,
  output logic [LANES-1:0] start_pend,
  output logic [LANES-1:0] stop_now
);
  logic [LANES-1:0] start_raw;

  always_comb begin
    start_raw = '0;
    stop_now  = '0;
    if (op_we) begin
      unique case (opc_e'(opc1))
        OPC_START_MASK: start_raw[2:0] = opc2;
        OPC_START_DBG:  start_raw[LANE_DBG] = 1'b1;
        OPC_STOP_MASK:  stop_now[2:0] = opc2;
        OPC_STOP_DBG:   stop_now[LANE_DBG] = 1'b1;
        default: ;
      endcase
    end
  end

  // The start register is the one-clock start delay stage.
  always_ff @(posedge clk) begin
    if (rst) start_pend <= '0;
    else     start_pend <= start_raw;
  end

  AST_EMPTY_MASK_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (op_we && !opc1[0] && opc2 == 3'd0) |-> (stop_now == '0)) else $error("empty mask stopped"); // R5
  AST_EMPTY_MASK_NO_START: assert property (@(posedge clk) disable iff (rst)
    (op_we && !opc1[0] && opc2 == 3'd0) |=> (start_pend == '0)) else $error("empty mask started"); // R5
  AST_DBG_ANY_OPC2: assert property (@(posedge clk) disable iff (rst)
    (op_we && opc1 == 2'd3) |-> stop_now[LANE_DBG]) else $error("debug stop lost"); // R3
endmodule

// File: rtl/vtc_lane.sv
module vtc_lane #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_pend,
  input  logic             stop,
  input  logic             release_evt,
  input  logic             ld_we,
  input  logic [CNT_W-1:0] ld_data,
  output logic [CNT_W-1:0] cnt,
  output logic             evt_n
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic run_q;
  logic advance;
  logic wrap;

  assign advance = run_q && !stop && !ld_we;
  assign wrap    = advance && (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt   <= '0;
      evt_n <= 1'b1;
    end else begin
      if (stop)            run_q <= 1'b0;
      else if (start_pend) run_q <= 1'b1;

      if (ld_we)        cnt <= ld_data;
      else if (advance) cnt <= cnt + CNT_ONE;

      if (wrap)                      evt_n <= 1'b0;
      else if (stop || release_evt)  evt_n <= 1'b1;
    end
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    (run_q && !stop && !ld_we && cnt == CNT_MAX) |=> (cnt == '0 && !evt_n)) else $error("wrap"); // R6
  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!evt_n && !stop && !release_evt) |=> !evt_n) else $error("event dropped"); // R8
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (stop && !ld_we) |=> ($stable(cnt) && evt_n)) else $error("stop"); // R4
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    ld_we |=> (cnt == $past(ld_data))) else $error("load"); // R9
  AST_START_DELAY: assert property (@(posedge clk) disable iff (rst)
    (start_pend && !run_q && !ld_we) |=> $stable(cnt)) else $error("early count"); // R2
endmodule

// File: rtl/vtc_readback.sv
module vtc_readback
  import vtc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int LANES = NUM_LANES,
  parameter int SEL_W = 3,
  parameter logic [LANES-1:0] READABLE = READABLE_LANES
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [SEL_W-1:0]            rd_sel,
  input  logic [LANES-1:0][CNT_W-1:0] cnt_all,
  output logic [CNT_W-1:0]            rd_data
);
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [IDX_W-1:0] idx;
  logic             hit;

  assign idx = rd_sel[IDX_W-1:0];
  assign hit = (32'(rd_sel) < LANES) && READABLE[idx];

  always_ff @(posedge clk) begin
    if (rst)      rd_data <= '0;
    else if (hit) rd_data <= cnt_all[idx];
    else          rd_data <= '0;
  end

  AST_HIDDEN_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (32'(rd_sel) >= LANES || !READABLE[idx]) |=> (rd_data == '0)) else $error("hidden read"); // R10
  AST_READ_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (32'(rd_sel) < LANES && READABLE[idx]) |=> (rd_data == $past(cnt_all[idx]))) else $error("read"); // R10
endmodule

// File: rtl/valevt_trigger.sv
module valevt_trigger
  import vtc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int CTL_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_we,
  input  logic [1:0]       op_opc1,
  input  logic [2:0]       op_opc2,
  input  logic             ld_we,
  input  logic [1:0]       ld_sel,
  input  logic [CNT_W-1:0] ld_data,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_data,
  input  logic [2:0]       rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic             evt_rst_n,
  output logic             evt_irq_n,
  output logic             evt_fiq_n,
  output logic             evt_dbg_n
);
  localparam int LANES = NUM_LANES;

  logic [LANES-1:0]            start_pend;
  logic [LANES-1:0]            stop_now;
  logic [LANES-1:0]            rel;
  logic [LANES-1:0]            ld_hit;
  logic [LANES-1:0]            evt_n;
  logic [LANES-1:0][CNT_W-1:0] cnt_all;
  logic                        ctl_unused;

  assign ctl_unused = ^{ctl_data[CTL_W-1:REL_BIT_RST+1], ctl_data[REL_BIT_IRQ-1:0]};

  assign rel[LANE_RST] = ctl_we && ctl_data[REL_BIT_RST];
  assign rel[LANE_IRQ] = ctl_we && ctl_data[REL_BIT_IRQ];
  assign rel[LANE_FIQ] = ctl_we && ctl_data[REL_BIT_FIQ];
  assign rel[LANE_DBG] = 1'b0;

  vtc_op_decode #(.LANES(LANES)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .op_we      (op_we),
    .opc1       (op_opc1),
    .opc2       (op_opc2),
    .start_pend (start_pend),
    .stop_now   (stop_now)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign ld_hit[g] = ld_we && (ld_sel == 2'(g));

    vtc_lane #(.CNT_W(CNT_W)) u_lane (
      .clk         (clk),
      .rst         (rst),
      .start_pend  (start_pend[g]),
      .stop        (stop_now[g]),
      .release_evt (rel[g]),
      .ld_we       (ld_hit[g]),
      .ld_data     (ld_data),
      .cnt         (cnt_all[g]),
      .evt_n       (evt_n[g])
    );
  end

  vtc_readback #(.CNT_W(CNT_W), .LANES(LANES), .SEL_W(3)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_sel  (rd_sel),
    .cnt_all (cnt_all),
    .rd_data (rd_data)
  );

  assign evt_rst_n = evt_n[LANE_RST];
  assign evt_irq_n = evt_n[LANE_IRQ];
  assign evt_fiq_n = evt_n[LANE_FIQ];
  assign evt_dbg_n = evt_n[LANE_DBG];

  AST_DBG_NOT_RELEASED_BY_CTL: assert property (@(posedge clk) disable iff (rst)
    (!evt_dbg_n && ctl_we && !stop_now[LANE_DBG]) |=> !evt_dbg_n) else $error("dbg released"); // R8
endmodule

// File: tb/valevt_trigger_tb.sv
`timescale 1ns/1ps
module valevt_trigger_tb;
  localparam int W  = 8;
  localparam int CW = 32;
  localparam int MAXV = (1 << W) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_we = 1'b0;
  logic [1:0]    op_opc1 = '0;
  logic [2:0]    op_opc2 = '0;
  logic          ld_we = 1'b0;
  logic [1:0]    ld_sel = '0;
  logic [W-1:0]  ld_data = '0;
  logic          ctl_we = 1'b0;
  logic [CW-1:0] ctl_data = '0;
  logic [2:0]    rd_sel = '0;
  logic [W-1:0]  rd_data;
  logic          evt_rst_n, evt_irq_n, evt_fiq_n, evt_dbg_n;
  logic [3:0]    evt;

  assign evt = {evt_dbg_n, evt_fiq_n, evt_irq_n, evt_rst_n};

  always #2.5 clk = ~clk;

  valevt_trigger #(.CNT_W(W), .CTL_W(CW)) u_dut (
    .clk(clk), .rst(rst), .op_we(op_we), .op_opc1(op_opc1), .op_opc2(op_opc2),
    .ld_we(ld_we), .ld_sel(ld_sel), .ld_data(ld_data), .ctl_we(ctl_we),
    .ctl_data(ctl_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .evt_rst_n(evt_rst_n), .evt_irq_n(evt_irq_n), .evt_fiq_n(evt_fiq_n),
    .evt_dbg_n(evt_dbg_n)
  );

  typedef struct {
    int          due;
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t sbq[$];
  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares each queued item once its sampling cycle is reached.
  always @(negedge clk) begin
    item_t it;
    logic [31:0] act;
    while (sbq.size() > 0 && sbq[0].due == cyc) begin
      it  = sbq.pop_front();
      act = (it.kind == 0) ? 32'(rd_data) : {28'd0, evt};
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d cycle=%0d actual=%h expected=%h", it.req, it.kind, cyc, act, it.exp);
      end
    end
  end

  function automatic logic [31:0] wv(int v);
    return 32'(v & MAXV);
  endfunction

  task automatic push(int due, int kind, logic [31:0] exp, string req);
    item_t it;
    it.due = due; it.kind = kind; it.exp = exp; it.req = req;
    sbq.push_back(it);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic op(logic [1:0] o1, logic [2:0] o2);
    op_we = 1'b1; op_opc1 = o1; op_opc2 = o2;
    @(negedge clk);
    op_we = 1'b0;
  endtask

  task automatic ld(logic [1:0] sel, int val);
    ld_we = 1'b1; ld_sel = sel; ld_data = W'(val);
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic rel(logic [CW-1:0] bits);
    ctl_we = 1'b1; ctl_data = bits;
    @(negedge clk);
    ctl_we = 1'b0; ctl_data = '0;
  endtask

  task automatic rd(logic [2:0] sel, logic [31:0] exp, string req);
    rd_sel = sel;
    push(cyc + 1, 0, exp, req);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int a, s, s1, s2, l, n;
    int rstv;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    rd(3'd0, 0, "R1");
    rd(3'd1, 0, "R1");
    rd(3'd2, 0, "R1");
    push(cyc + 1, 1, 32'hF, "R1");
    idle(1);

    // R9 / R10: loads and read rules
    ld(2'd0, 8'h5A); ld(2'd1, 8'h33); ld(2'd2, 8'h44); ld(2'd3, 8'h77);
    rd(3'd0, 32'h5A, "R9");
    rd(3'd1, 32'h33, "R9");
    rd(3'd2, 32'h44, "R9");
    rd(3'd3, 0, "R10 debug hidden");
    rd(3'd4, 0, "R10 op port");
    rd(3'd7, 0, "R10 unused select");

    // R5: empty masks do nothing while stopped
    op(2'd0, 3'd0);
    op(2'd2, 3'd0);
    idle(3);
    rd(3'd0, 32'h5A, "R5");
    rd(3'd1, 32'h33, "R5");
    rd(3'd2, 32'h44, "R5");

    // R2: start latency
    rstv = 8'h5A;
    op(2'd0, 3'd1); a = cyc;
    op(2'd2, 3'd1);
    rd(3'd0, 32'h5A, "R2 stop on next edge");
    op(2'd0, 3'd1); a = cyc;
    idle(2);
    op(2'd2, 3'd1); s = cyc;
    rstv = rstv + s - a - 2;
    rd(3'd0, wv(rstv), "R2");

    // R5: empty stop mask does not stop a running counter
    op(2'd0, 3'd1); a = cyc;
    idle(2);
    op(2'd2, 3'd0);
    idle(3);
    op(2'd2, 3'd1); s = cyc;
    rstv = rstv + s - a - 2;
    rd(3'd0, wv(rstv), "R5 running");

    // R4: masked stop leaves other lanes running
    ld(2'd0, 8'h10); ld(2'd1, 8'h20);
    op(2'd0, 3'd3); a = cyc;
    idle(4);
    op(2'd2, 3'd2); s1 = cyc;
    idle(3);
    op(2'd2, 3'd1); s2 = cyc;
    rd(3'd1, wv(8'h20 + s1 - a - 2), "R4 irq");
    rd(3'd0, wv(8'h10 + s2 - a - 2), "R4 rst");
    idle(5);
    rd(3'd1, wv(8'h20 + s1 - a - 2), "R4 hold");

    // R9: load while running, then counting resumes
    op(2'd0, 3'd4);
    idle(3);
    ld(2'd2, 8'hC0); l = cyc;
    idle(2);
    op(2'd2, 3'd4); s = cyc;
    rd(3'd2, wv(8'hC0 + s - l - 1), "R9 load priority");

    // R6 / R7: simultaneous wraps
    n = 6;
    ld(2'd0, MAXV - n); ld(2'd1, MAXV - n); ld(2'd2, MAXV - n);
    op(2'd0, 3'd7); a = cyc;
    push(a + n + 1, 1, 32'hF, "R6 not early");
    push(a + n + 2, 1, 32'h8, "R7");
    idle(n + 4);

    // R8: releases map to the right lanes
    rel(32'h200);
    push(cyc + 1, 1, 32'hC, "R8 bit9 fast irq");
    idle(1);
    rel(32'h100);
    push(cyc + 1, 1, 32'hE, "R8 bit8 irq");
    idle(1);
    rel(32'h400);
    push(cyc + 1, 1, 32'hF, "R8 bit10 reset");
    idle(1);
    op(2'd2, 3'd7); s = cyc;
    rd(3'd0, wv(MAXV - n + s - a - 2), "R6 post wrap");

    // R3: debug lane started with secondary 0, released only by stop
    n = 4;
    ld(2'd3, MAXV - n);
    op(2'd1, 3'd0); a = cyc;
    push(a + n + 1, 1, 32'hF, "R3 not early");
    push(a + n + 2, 1, 32'h7, "R3");
    idle(n + 6);
    rel(32'h700);
    push(cyc + 1, 1, 32'h7, "R8 debug ignores release");
    idle(1);
    op(2'd3, 3'd6); s = cyc;
    push(s + 1, 1, 32'hF, "R3 stop");
    idle(2);

    wait (sbq.size() == 0);
    idle(1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule